// File: doc/BRIEF.md
# One-Hot Funnel Barrel Shifter

This block is a purely combinational shifter built around a funnel. Two WIDTH-bit words, an upper word and a lower word, are stacked into a 2·WIDTH-bit funnel. A strictly one-hot column vector then picks one contiguous WIDTH-bit window out of that funnel. Whether the result is a logical right shift, a logical left shift or a right rotate depends only on which words the front end loads into the two halves. The window logic itself never changes.

A small front end turns a 2-bit operation code and a binary distance into the word placement and the column. The column is decoded internally into the one-hot vector. For datapath experiments the caller can also supply the one-hot column directly. A malformed external column is caught, flagged and turned into an all-zero result rather than a blend of several windows. Every distance from 0 to WIDTH-1 settles in one combinational evaluation. WIDTH must be a power of two.

Top module: `funnel_shifter`

## Requirements
- R1: The funnel holds the upper word in bits [WIDTH-1:0] and the lower word in bits [2·WIDTH-1:WIDTH]. With column c active, output bit i equals funnel bit i+c.
- R2: The binary distance `shift_amt` is decoded inside the block into a one-hot column with exactly one active line, so any distance 0..WIDTH-1 selects its own window.
- R3: Operation code 2'b00 is a logical right shift. The data sits in the upper word and zeros in the lower word, so `data_out` = `data_in` >> `shift_amt`, with zeros entering at the top.
- R4: Operation code 2'b01 is a logical left shift. For a non-zero distance s, zeros go in the upper word, the data in the lower word, and column WIDTH-s is used. The result is `data_in` << s, with zeros entering at the bottom.
- R5: Operation code 2'b10 is a right rotate. The same data word is placed in both halves, so `data_out` = `data_in` rotated right by `shift_amt`.
- R6: Operation code 2'b11 is reserved and behaves as pass-through. `data_out` = `data_in` for every `shift_amt`.
- R7: When `sel_ext_en` is 1, `sel_ext` replaces the decoded column and the placement still follows the operation code. If `sel_ext` is not exactly one-hot (no bits set, or two or more bits set), `sel_err` is 1 and `data_out` is all zeros. Otherwise `sel_err` is 0. When `sel_ext_en` is 0, `sel_ext` has no effect and `sel_err` is 0.
- R8: A distance of 0 with the internal decoder returns `data_in` unchanged under all four operation codes.
- R9: The result follows a change of any input within the same evaluation. A new distance, code or word on every consecutive cycle gives the matching output on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | WIDTH | Operand word |
| shift_amt | input | log2(WIDTH) | Binary shift or rotate distance |
| mode | input | 2 | Operation code: 00 right shift, 01 left shift, 10 rotate right, 11 pass-through |
| sel_ext_en | input | 1 | Use `sel_ext` as the column instead of the decoded distance |
| sel_ext | input | WIDTH | Externally supplied one-hot column |
| data_out | output | WIDTH | Selected window |
| sel_err | output | 1 | External column not one-hot; output forced to zero |

## Verification
Within a single evaluation, the window selection and the external-column error guard both act on the same result. A malformed column must win over a placement that would otherwise produce non-zero data. The bench provokes this by driving a two-hot column while rotate mode loads the data into both halves, and by driving an all-zero column while left-shift placement is active. In both cases it requires an all-zero output with the flag raised. The bench also drives a garbage column with the override disabled and judges that the decoded distance alone sets the result, with the flag low.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  typedef enum logic [1:0] {
    OP_SHR  = 2'b00,
    OP_SHL  = 2'b01,
    OP_ROR  = 2'b10,
    OP_PASS = 2'b11
  } shift_op_e;

endpackage

// File: rtl/fsh_operand_stage.sv
module fsh_operand_stage
  import fsh_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  shift_op_e        op_i,
  output logic [WIDTH-1:0] upper_o,
  output logic [WIDTH-1:0] lower_o,
  output logic [AMT_W-1:0] col_o
);

  localparam logic [AMT_W-1:0] ONE_A = 1;

  // Placement decides the operation; the column is the distance or its
  // two's complement (WIDTH - s for a left shift, WIDTH being a power of two).
  always_comb begin
    upper_o = data_i;
    lower_o = '0;
    col_o   = '0;
    case (op_i)
      OP_SHR: begin
        upper_o = data_i;
        lower_o = '0;
        col_o   = amt_i;
      end
      OP_SHL: begin
        if (amt_i == '0) begin
          upper_o = data_i;
          lower_o = '0;
          col_o   = '0;
        end else begin
          upper_o = '0;
          lower_o = data_i;
          col_o   = ~amt_i + ONE_A;
        end
      end
      OP_ROR: begin
        upper_o = data_i;
        lower_o = data_i;
        col_o   = amt_i;
      end
      default: begin
        upper_o = data_i;
        lower_o = '0;
        col_o   = '0;
      end
    endcase
  end

endmodule

// File: rtl/fsh_onehot_decode.sv
module fsh_onehot_decode #(
  parameter int WIDTH = 16,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [AMT_W-1:0] col_i,
  output logic [WIDTH-1:0] onehot_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    assign onehot_o[g] = (col_i == AMT_W'(g));
  end

  always_comb begin
    if (!$isunknown(col_i)) begin
      assert_decode_onehot_R2: assert ($onehot(onehot_o));
    end
  end

endmodule

// File: rtl/fsh_select_guard.sv
module fsh_select_guard #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] dec_sel_i,
  input  logic             ext_en_i,
  input  logic [WIDTH-1:0] ext_sel_i,
  output logic [WIDTH-1:0] sel_o,
  output logic             err_o
);

  logic [WIDTH-1:0] raw_sel;
  logic             seen  [WIDTH+1];
  logic             multi [WIDTH+1];

  assign raw_sel  = ext_en_i ? ext_sel_i : dec_sel_i;
  assign seen[0]  = 1'b0;
  assign multi[0] = 1'b0;

  // Ripple scan: "seen" is any lower bit set, "multi" is a second set bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_scan
    assign seen[i+1]  = seen[i] | raw_sel[i];
    assign multi[i+1] = multi[i] | (seen[i] & raw_sel[i]);
  end

  assign err_o = ext_en_i & ~(seen[WIDTH] & ~multi[WIDTH]);
  assign sel_o = err_o ? '0 : raw_sel;

  always_comb begin
    if (!$isunknown({ext_en_i, ext_sel_i, dec_sel_i})) begin
      if (!err_o) begin
        assert_guard_onehot_R7: assert ($onehot(sel_o));
      end else begin
        assert_guard_blank_R7: assert (sel_o == '0);
      end
      if (!ext_en_i) begin
        assert_guard_noerr_R7: assert (!err_o);
      end
    end
  end

endmodule

// File: rtl/fsh_window_mux.sv
module fsh_window_mux #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] upper_i,
  input  logic [WIDTH-1:0] lower_i,
  input  logic [WIDTH-1:0] sel_i,
  output logic [WIDTH-1:0] win_o
);

  localparam int FUN_W = 2 * WIDTH;

  logic [FUN_W-1:0] funnel;
  logic [WIDTH-1:0] acc [WIDTH+1];

  assign funnel = {lower_i, upper_i};
  assign acc[0] = '0;

  // One AND-OR column per window position.
  for (genvar c = 0; c < WIDTH; c++) begin : g_col
    assign acc[c+1] = acc[c] | (funnel[c +: WIDTH] & {WIDTH{sel_i[c]}});
  end

  assign win_o = acc[WIDTH];

  always_comb begin
    if (!$isunknown(sel_i) && sel_i == '0) begin
      assert_window_empty_R1: assert (win_o == '0);
    end
    if (!$isunknown({sel_i, upper_i, lower_i}) && sel_i[0]) begin
      assert_window_col0_R1: assert (win_o == upper_i);
    end
  end

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
  import fsh_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [AMT_W-1:0] shift_amt,
  input  logic [1:0]       mode,
  input  logic             sel_ext_en,
  input  logic [WIDTH-1:0] sel_ext,
  output logic [WIDTH-1:0] data_out,
  output logic             sel_err
);

  shift_op_e        op;
  logic [WIDTH-1:0] upper_w;
  logic [WIDTH-1:0] lower_w;
  logic [AMT_W-1:0] col_bin;
  logic [WIDTH-1:0] col_dec;
  logic [WIDTH-1:0] col_fin;

  assign op = shift_op_e'(mode);

  fsh_operand_stage #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_place (
    .data_i  (data_in),
    .amt_i   (shift_amt),
    .op_i    (op),
    .upper_o (upper_w),
    .lower_o (lower_w),
    .col_o   (col_bin)
  );

  fsh_onehot_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dec (
    .col_i    (col_bin),
    .onehot_o (col_dec)
  );

  fsh_select_guard #(.WIDTH(WIDTH)) u_guard (
    .dec_sel_i (col_dec),
    .ext_en_i  (sel_ext_en),
    .ext_sel_i (sel_ext),
    .sel_o     (col_fin),
    .err_o     (sel_err)
  );

  fsh_window_mux #(.WIDTH(WIDTH)) u_win (
    .upper_i (upper_w),
    .lower_i (lower_w),
    .sel_i   (col_fin),
    .win_o   (data_out)
  );

  always_comb begin
    if (!$isunknown({data_in, shift_amt, mode, sel_ext_en, sel_ext})) begin
      if (sel_err) begin
        assert_err_zero_R7: assert (data_out == '0);
      end
      if (!sel_ext_en && shift_amt == '0) begin
        assert_zero_dist_R8: assert (data_out == data_in);
      end
      if (!sel_ext_en && mode == 2'b11) begin
        assert_pass_R6: assert (data_out == data_in);
      end
      if (!sel_ext_en && mode == 2'b10) begin
        assert_rot_ones_R5: assert ($countones(data_out) == $countones(data_in));
      end
      if (!sel_ext_en && mode == 2'b00 && shift_amt != '0) begin
        assert_shr_fill_R3: assert (!data_out[WIDTH-1]);
      end
      if (!sel_ext_en && mode == 2'b01 && shift_amt != '0) begin
        assert_shl_fill_R4: assert (!data_out[0]);
      end
    end
  end

endmodule

// File: tb/funnel_shifter_bench.sv
`timescale 1ns/1ps
module funnel_shifter_bench;

  localparam int W  = 16;
  localparam int AW = $clog2(W);

  typedef struct {
    logic [W-1:0] exp_out;
    logic         exp_err;
    string        tag;
  } item_t;

  logic          clk = 1'b0;
  logic [W-1:0]  data_in = '0;
  logic [AW-1:0] shift_amt = '0;
  logic [1:0]    mode = 2'b00;
  logic          sel_ext_en = 1'b0;
  logic [W-1:0]  sel_ext = '0;
  logic [W-1:0]  data_out;
  logic          sel_err;

  item_t q [$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #4 clk = ~clk;

  funnel_shifter #(.WIDTH(W)) u_funnel_shifter (
    .data_in    (data_in),
    .shift_amt  (shift_amt),
    .mode       (mode),
    .sel_ext_en (sel_ext_en),
    .sel_ext    (sel_ext),
    .data_out   (data_out),
    .sel_err    (sel_err)
  );

  function automatic item_t predict(logic [W-1:0] d, int s, logic [1:0] m,
                                    logic en, logic [W-1:0] ext, string tag);
    item_t        it;
    logic [2*W-1:0] fun;
    logic [W-1:0] up;
    logic [W-1:0] lo;
    int           col;
    it.tag = tag;
    it.exp_err = 1'b0;
    if (!en) begin
      case (m)
        2'b00: it.exp_out = d >> s;
        2'b01: it.exp_out = d << s;
        2'b10: begin fun = {d, d} >> s; it.exp_out = fun[W-1:0]; end
        default: it.exp_out = d;
      endcase
    end else if ($countones(ext) != 1) begin
      it.exp_out = '0;
      it.exp_err = 1'b1;
    end else begin
      col = 0;
      for (int k = 0; k < W; k++) if (ext[k]) col = k;
      up = d; lo = '0;
      if (m == 2'b01 && s != 0) begin up = '0; lo = d; end
      if (m == 2'b10) lo = d;
      fun = {lo, up} >> col;
      it.exp_out = fun[W-1:0];
    end
    return it;
  endfunction

  task automatic drive(logic [W-1:0] d, int s, logic [1:0] m,
                       logic en, logic [W-1:0] ext, string tag);
    @(posedge clk);
    #1;
    data_in    = d;
    shift_amt  = AW'(s);
    mode       = m;
    sel_ext_en = en;
    sel_ext    = ext;
    q.push_back(predict(d, s, m, en, ext, tag));
  endtask

  // Monitor: compare at the falling edge, away from the drive point.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (data_out !== it.exp_out || sel_err !== it.exp_err) begin
        n_bad++;
        $display("FAIL %s: out=%h err=%b expected out=%h err=%b",
                 it.tag, data_out, sel_err, it.exp_out, it.exp_err);
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    drive('0, 0, 2'b00, 1'b0, '0, "R1 idle all-zero inputs");
    drive(16'h8001, 1, 2'b00, 1'b0, '0, "R3 right shift by 1");
    drive(16'hFFFF, 15, 2'b00, 1'b0, '0, "R3 R2 right shift by 15");
    drive(16'h8001, 1, 2'b01, 1'b0, '0, "R4 left shift by 1");
    drive(16'hFFFF, 15, 2'b01, 1'b0, '0, "R4 left shift by 15");
    drive(16'h0001, 1, 2'b10, 1'b0, '0, "R5 rotate lsb to msb");
    drive(16'h1234, 4, 2'b10, 1'b0, '0, "R5 rotate by nibble");
    drive(16'hBEEF, 7, 2'b11, 1'b0, '0, "R6 pass-through ignores distance");
    // R8: zero distance in every mode
    for (int m = 0; m < 4; m++) begin
      drive(16'hC35A, 0, 2'(m), 1'b0, '0, "R8 zero distance");
      drive(16'h7FFE, 0, 2'(m), 1'b0, '0, "R8 zero distance");
    end
    // R9 and R2: new distance each cycle, all modes, two patterns
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < W; s++) begin
        drive(16'hA5C3, s, 2'(m), 1'b0, '0, "R9 R2 back-to-back sweep");
        drive(16'h0F01, W - 1 - s, 2'(m), 1'b0, '0, "R9 R2 descending sweep");
      end
    end
    // R7 and R1: external column
    drive(16'h1234, 0, 2'b00, 1'b1, 16'h0010, "R7 R1 ext column 4 right placement");
    drive(16'h1234, 3, 2'b01, 1'b1, 16'h0001, "R7 R1 ext column 0 left placement");
    drive(16'h1234, 0, 2'b10, 1'b1, 16'h8000, "R7 R1 ext column 15 rotate placement");
    drive(16'hFFFF, 0, 2'b10, 1'b1, 16'h0011, "R7 two-hot column in rotate");
    drive(16'hFFFF, 5, 2'b01, 1'b1, 16'h0000, "R7 empty column in left shift");
    drive(16'hFFFF, 0, 2'b00, 1'b1, 16'hFFFF, "R7 all-hot column");
    drive(16'h00F0, 4, 2'b00, 1'b0, 16'h0101, "R7 ext column ignored when disabled");
    drive(16'hFFFF, 0, 2'b10, 1'b1, 16'hC000, "R7 two-hot at top");
    drive(16'h00F0, 4, 2'b10, 1'b0, 16'h0000, "R7 recovery after error");
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule